// File: doc/BRIEF.md
# Paged 32-bit Register Bridge over 16-bit Management Accesses

This block lets a management host that only issues 16-bit register accesses reach a 32-bit internal register space. It sits behind an MDIO framer, which hands it decoded transactions: a PHY address, a 5-bit register number, a direction and 16 bits of write data. The bridge answers only one PHY address. At that address, register 0x1f is a page register that holds the upper bits of the internal byte address. Registers 0x0 to 0xf pick one of sixteen 32-bit words within the page and carry the lower data half. Register 0x10 carries the upper data half.

To write a word, the host loads the page, writes the lower half to the word-select register, and then writes the upper half to 0x10. The bridge issues the internal 32-bit write only on that last step. To read a word, the host loads the page and reads the word-select register. That read does the whole internal read at once, returns the lower half and keeps the upper half. A read of 0x10 then returns the upper half of the same word. The internal bus is a single-cycle bus: a write is a one-cycle strobe, and read data is valid in the same cycle the read strobe is high.

Top module: `mdio_page_bridge`

## Requirements
- R1: Only transactions whose PHY address is 0x1f are claimed. A transaction at any other PHY address raises neither internal strobe and no response. It also leaves the page and both held halves unchanged.
- R2: A claimed write to register 0x1f loads write-data bits 9:0 into the page. A claimed read of 0x1f returns the page zero-extended to 16 bits.
- R3: A claimed write to a register 0x0 to 0xf raises no internal strobe. It keeps the data as the pending lower half, and it keeps {page, regnum[3:0]} as the pending word address.
- R4: A claimed write to register 0x10 raises the internal write strobe for exactly that cycle. The byte address is {pending word address, 2'b00}, and the data is {write data, pending lower half}. A page change made between the two writes does not move the target.
- R5: A claimed read of a register 0x0 to 0xf raises the internal read strobe in that same cycle, at byte address {page, regnum[3:0], 2'b00}. It returns bits 15:0 of the internal read data.
- R6: A claimed read of register 0x10 returns bits 31:16 of the word fetched by the most recent low-half read. Reads of 0x10 do not refresh that value.
- R7: After reset the page, the pending lower half, the pending word address and the held upper half are all zero.
- R8: Claimed writes to registers 0x11 to 0x1e have no effect. Claimed reads of them return zero.
- R9: The response-valid output is high for exactly the one cycle after each claimed read, and low after writes and idle cycles. The response data is valid in that cycle.
- R10: The internal write and read strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_valid | input | 1 | A decoded management transaction is present this cycle |
| txn_write | input | 1 | 1 = register write, 0 = register read |
| txn_phy | input | 5 | PHY address of the transaction |
| txn_reg | input | 5 | Register number of the transaction |
| txn_wdata | input | 16 | Write data of the transaction |
| txn_claim | output | 1 | The transaction targets this bridge |
| rsp_valid | output | 1 | Read response present (one cycle after the read) |
| rsp_data | output | 16 | Read response data |
| bus_addr | output | 16 | Internal byte address (bits 1:0 always zero) |
| bus_wr | output | 1 | Internal write strobe, one cycle |
| bus_rd | output | 1 | Internal read strobe |
| bus_wdata | output | 32 | Internal write data |
| bus_rdata | input | 32 | Internal read data, valid while bus_rd is high |

## Verification
Two things can overlap in time: a pending low-half write waiting for its 0x10 commit, and the read path, which reuses the same bus address lines and refreshes the held upper half. The bench provokes this by placing low-half reads and page rewrites between a low-half write and its commit. It then judges the commit's address and data against the word that was selected when the low half was written. It also checks that a later read of 0x10 reflects the intervening read rather than the pending write. A sweep over several pages and all sixteen word selects compares every strobe, address and returned half against a read pattern computed from the address.

// File: rtl/mpb_pkg.sv
package mpb_pkg;

  localparam int HALF_W = 16;
  localparam logic [4:0] PAGE_REGNUM = 5'h1f;
  localparam logic [4:0] HI_REGNUM   = 5'h10;

  typedef enum logic [2:0] {
    SLOT_NONE,
    SLOT_PAGE,
    SLOT_LO,
    SLOT_HI,
    SLOT_GAP
  } slot_e;

  function automatic slot_e slot_of(input logic hit, input logic [4:0] regnum);
    if (!hit)                       return SLOT_NONE;
    else if (regnum == PAGE_REGNUM) return SLOT_PAGE;
    else if (!regnum[4])            return SLOT_LO;
    else if (regnum == HI_REGNUM)   return SLOT_HI;
    else                            return SLOT_GAP;
  endfunction

endpackage

// File: rtl/mpb_decode.sv
module mpb_decode
  import mpb_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'h1f
) (
  input  logic       txn_valid,
  input  logic       txn_write,
  input  logic [4:0] txn_phy,
  input  logic [4:0] txn_reg,
  output logic       hit,
  output logic       ev_page_wr,
  output logic       ev_page_rd,
  output logic       ev_lo_wr,
  output logic       ev_lo_rd,
  output logic       ev_hi_wr,
  output logic       ev_hi_rd,
  output logic       ev_gap_rd
);
  slot_e slot;

  always_comb begin
    hit        = txn_valid && (txn_phy == PHY_ADDR);
    slot       = slot_of(hit, txn_reg);
    ev_page_wr = (slot == SLOT_PAGE) &&  txn_write;
    ev_page_rd = (slot == SLOT_PAGE) && !txn_write;
    ev_lo_wr   = (slot == SLOT_LO)   &&  txn_write;
    ev_lo_rd   = (slot == SLOT_LO)   && !txn_write;
    ev_hi_wr   = (slot == SLOT_HI)   &&  txn_write;
    ev_hi_rd   = (slot == SLOT_HI)   && !txn_write;
    ev_gap_rd  = (slot == SLOT_GAP)  && !txn_write;
  end
endmodule

// File: rtl/mpb_page_reg.sv
module mpb_page_reg #(
  parameter int PAGE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W-1:0] din,
  output logic [PAGE_W-1:0] page
);
  always_ff @(posedge clk) begin
    if (!rst_n)    page <= '0;
    else if (load) page <= din;
  end
endmodule

// File: rtl/mpb_wr_stage.sv
module mpb_wr_stage
  import mpb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [HALF_W-1:0] wdata,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [2*HALF_W-1:0] bus_wdata
);
  logic [HALF_W-1:0] lo_hold;
  logic [ADDR_W-1:0] addr_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_hold   <= '0;
      addr_hold <= '0;
    end else if (lo_wr) begin
      lo_hold   <= wdata;
      addr_hold <= addr_in;
    end
  end

  always_comb begin
    bus_wr    = hi_wr;
    wr_addr   = addr_hold;
    bus_wdata = {wdata, lo_hold};
  end
endmodule

// File: rtl/mpb_rd_stage.sv
module mpb_rd_stage
  import mpb_pkg::*;
#(
  parameter int PAGE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lo_rd,
  input  logic                hi_rd,
  input  logic                page_rd,
  input  logic                gap_rd,
  input  logic [PAGE_W-1:0]   page,
  input  logic [2*HALF_W-1:0] bus_rdata,
  output logic                bus_rd,
  output logic                rsp_valid,
  output logic [HALF_W-1:0]   rsp_data
);
  logic [HALF_W-1:0] hi_hold;
  logic [HALF_W-1:0] rsp_next;
  logic              any_rd;

  always_comb begin
    bus_rd = lo_rd;
    any_rd = lo_rd || hi_rd || page_rd || gap_rd;
    if (lo_rd)        rsp_next = bus_rdata[HALF_W-1:0];
    else if (hi_rd)   rsp_next = hi_hold;
    else if (page_rd) rsp_next = {{(HALF_W-PAGE_W){1'b0}}, page};
    else              rsp_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_hold   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= any_rd;
      if (any_rd) rsp_data <= rsp_next;
      if (lo_rd)  hi_hold  <= bus_rdata[2*HALF_W-1:HALF_W];
    end
  end
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mpb_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'h1f,
  parameter int         PAGE_W   = 10,
  parameter int         SEL_W    = 4,
  localparam int        ADDR_W   = PAGE_W + SEL_W + 2,
  localparam int        WORD_W   = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_valid,
  input  logic              txn_write,
  input  logic [4:0]        txn_phy,
  input  logic [4:0]        txn_reg,
  input  logic [HALF_W-1:0] txn_wdata,
  output logic              txn_claim,
  output logic              rsp_valid,
  output logic [HALF_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] bus_rdata
);
  function automatic logic [ADDR_W-1:0] word_addr(input logic [PAGE_W-1:0] pg,
                                                   input logic [SEL_W-1:0]  sl);
    return {pg, sl, 2'b00};
  endfunction

  logic ev_page_wr, ev_page_rd, ev_lo_wr, ev_lo_rd, ev_hi_wr, ev_hi_rd, ev_gap_rd;
  logic [PAGE_W-1:0] page;
  logic [ADDR_W-1:0] sel_addr;
  logic [ADDR_W-1:0] wr_addr;

  mpb_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
    .txn_valid (txn_valid),
    .txn_write (txn_write),
    .txn_phy   (txn_phy),
    .txn_reg   (txn_reg),
    .hit       (txn_claim),
    .ev_page_wr(ev_page_wr),
    .ev_page_rd(ev_page_rd),
    .ev_lo_wr  (ev_lo_wr),
    .ev_lo_rd  (ev_lo_rd),
    .ev_hi_wr  (ev_hi_wr),
    .ev_hi_rd  (ev_hi_rd),
    .ev_gap_rd (ev_gap_rd)
  );

  mpb_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk  (clk),
    .rst_n(rst_n),
    .load (ev_page_wr),
    .din  (txn_wdata[PAGE_W-1:0]),
    .page (page)
  );

  assign sel_addr = word_addr(page, txn_reg[SEL_W-1:0]);

  mpb_wr_stage #(.ADDR_W(ADDR_W)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .lo_wr    (ev_lo_wr),
    .hi_wr    (ev_hi_wr),
    .wdata    (txn_wdata),
    .addr_in  (sel_addr),
    .bus_wr   (bus_wr),
    .wr_addr  (wr_addr),
    .bus_wdata(bus_wdata)
  );

  mpb_rd_stage #(.PAGE_W(PAGE_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .lo_rd    (ev_lo_rd),
    .hi_rd    (ev_hi_rd),
    .page_rd  (ev_page_rd),
    .gap_rd   (ev_gap_rd),
    .page     (page),
    .bus_rdata(bus_rdata),
    .bus_rd   (bus_rd),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data)
  );

  assign bus_addr = bus_wr ? wr_addr : sel_addr;
endmodule

// File: rtl/mpb_checker.sv
module mpb_checker #(
  parameter logic [4:0] PHY_ADDR = 5'h1f,
  parameter int         PAGE_W   = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txn_valid,
  input logic              txn_write,
  input logic [4:0]        txn_phy,
  input logic [4:0]        txn_reg,
  input logic [PAGE_W-1:0] wdata_page,
  input logic              txn_claim,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              rsp_valid,
  input logic [15:0]       rsp_data,
  input logic              ev_lo_wr
);
  // R10
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  // R1
  foreign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_phy != PHY_ADDR) |-> (!txn_claim && !bus_wr && !bus_rd));

  // R1
  foreign_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(txn_valid && txn_phy == PHY_ADDR) |=> !rsp_valid);

  // R9
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_claim && !txn_write) |=> rsp_valid);

  // R9
  no_rsp_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_claim && txn_write) |=> !rsp_valid);

  // R3
  lo_write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lo_wr |-> (!bus_wr && !bus_rd));

  // R4
  commit_only_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (txn_claim && txn_write && txn_reg == 5'h10));

  // R2
  page_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(txn_claim && txn_write && txn_reg == 5'h1f) &&
     txn_claim && !txn_write && txn_reg == 5'h1f)
    |=> rsp_data == {{(16-PAGE_W){1'b0}}, $past(wdata_page, 2)});
endmodule

bind mdio_page_bridge mpb_checker #(.PHY_ADDR(PHY_ADDR), .PAGE_W(PAGE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .txn_valid (txn_valid),
  .txn_write (txn_write),
  .txn_phy   (txn_phy),
  .txn_reg   (txn_reg),
  .wdata_page(txn_wdata[PAGE_W-1:0]),
  .txn_claim (txn_claim),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .ev_lo_wr  (ev_lo_wr)
);

// File: tb/sim_mdio_page_bridge.sv
`timescale 1ns/1ps
module sim_mdio_page_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txn_valid = 1'b0;
  logic        txn_write = 1'b0;
  logic [4:0]  txn_phy = 5'h0;
  logic [4:0]  txn_reg = 5'h0;
  logic [15:0] txn_wdata = 16'h0;
  logic        txn_claim;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [15:0] bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  // read pattern of the stand-in register space, derived from the address
  function automatic logic [31:0] pat(input logic [15:0] a);
    return {a ^ 16'h5a3c, a + 16'h1357};
  endfunction

  assign bus_rdata = pat(bus_addr);

  mdio_page_bridge u0 (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_write(txn_write),
    .txn_phy(txn_phy), .txn_reg(txn_reg), .txn_wdata(txn_wdata),
    .txn_claim(txn_claim), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit w, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    @(negedge clk);
    txn_valid = 1'b1; txn_write = w; txn_phy = phy; txn_reg = rg; txn_wdata = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    txn_valid = 1'b0; txn_write = 1'b0;
    #1;
  endtask

  task automatic wr(input logic [4:0] rg, input logic [15:0] d);
    drive(1'b1, 5'h1f, rg, d);
    idle();
    chk(rsp_valid == 1'b0, "R9 no response after write", 32'(rsp_valid), 32'd0);
  endtask

  task automatic rd_expect(input logic [4:0] rg, input logic [15:0] exp, input string tag);
    drive(1'b0, 5'h1f, rg, 16'h0);
    idle();
    chk(rsp_valid == 1'b1, "R9 response valid after read", 32'(rsp_valid), 32'd1);
    chk(rsp_data == exp, tag, 32'(rsp_data), 32'(exp));
  endtask

  task automatic commit_expect(input logic [15:0] hi, input logic [15:0] ea, input logic [31:0] ed, input string tag);
    drive(1'b1, 5'h1f, 5'h10, hi);
    chk(bus_wr == 1'b1 && bus_rd == 1'b0, {tag, " strobe"}, {bus_wr, bus_rd}, 32'd2);
    chk(bus_addr == ea, {tag, " address"}, 32'(bus_addr), 32'(ea));
    chk(bus_wdata == ed, {tag, " data"}, bus_wdata, ed);
    idle();
    chk(bus_wr == 1'b0, "R4 strobe lasts one cycle", 32'(bus_wr), 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [9:0]  pages [4];
    logic [15:0] ea;
    logic [31:0] w;
    pages[0] = 10'h000; pages[1] = 10'h001; pages[2] = 10'h2aa; pages[3] = 10'h3ff;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R7 reset state
    chk(rsp_valid == 1'b0 && bus_wr == 1'b0 && bus_rd == 1'b0, "R7 idle outputs after reset",
        {rsp_valid, bus_wr, bus_rd}, 32'd0);
    rd_expect(5'h1f, 16'h0000, "R7 page zero after reset");
    rd_expect(5'h10, 16'h0000, "R7 held upper half zero after reset");
    commit_expect(16'hbeef, 16'h0000, 32'hbeef0000, "R7 pending low half and address zero");

    // R2 page readback, upper write-data bits discarded
    wr(5'h1f, 16'hfd5a);
    rd_expect(5'h1f, 16'h015a, "R2 page readback");

    // sweep pages and word selects: R3 R4 R5 R6
    for (int p = 0; p < 4; p++) begin
      wr(5'h1f, {6'h3f, pages[p]});
      for (int s = 0; s < 16; s++) begin
        ea = {pages[p], s[3:0], 2'b00};
        w  = {ea ^ 16'hc001, ea + 16'h0f0f};
        drive(1'b1, 5'h1f, 5'(s), w[15:0]);
        // R3 low-half write raises no strobe
        chk(bus_wr == 1'b0 && bus_rd == 1'b0, "R3 low write quiet", {bus_wr, bus_rd}, 32'd0);
        idle();
        commit_expect(w[31:16], ea, w, "R4 commit");
        drive(1'b0, 5'h1f, 5'(s), 16'h0);
        chk(bus_rd == 1'b1 && bus_wr == 1'b0, "R5 read strobe", {bus_wr, bus_rd}, 32'd1);
        chk(bus_addr == ea, "R5 read address", 32'(bus_addr), 32'(ea));
        idle();
        chk(rsp_data == pat(ea)[15:0], "R5 lower half", 32'(rsp_data), 32'(pat(ea)[15:0]));
        rd_expect(5'h10, pat(ea)[31:16], "R6 upper half");
      end
    end

    // R4 page change and a low read between low write and commit
    wr(5'h1f, 16'h0123);
    wr(5'h05, 16'h7777);
    rd_expect(5'h09, pat({10'h123, 4'h9, 2'b00})[15:0], "R5 read while write pending");
    wr(5'h1f, 16'h0222);
    commit_expect(16'h8888, {10'h123, 4'h5, 2'b00}, 32'h88887777, "R4 commit keeps latched target");
    rd_expect(5'h10, pat({10'h123, 4'h9, 2'b00})[31:16], "R6 upper half from intervening read");
    rd_expect(5'h10, pat({10'h123, 4'h9, 2'b00})[31:16], "R6 repeated upper read unchanged");

    // R6 latest low read wins
    rd_expect(5'h02, pat({10'h222, 4'h2, 2'b00})[15:0], "R5 first read");
    rd_expect(5'h0e, pat({10'h222, 4'he, 2'b00})[15:0], "R5 second read");
    rd_expect(5'h10, pat({10'h222, 4'he, 2'b00})[31:16], "R6 latest low read wins");

    // R8 gap registers
    wr(5'h04, 16'h4444);
    for (int g = 17; g < 31; g++) begin
      drive(1'b1, 5'h1f, 5'(g), 16'hffff);
      chk(bus_wr == 1'b0 && bus_rd == 1'b0, "R8 gap write quiet", {bus_wr, bus_rd}, 32'd0);
      idle();
      rd_expect(5'(g), 16'h0000, "R8 gap read zero");
    end
    rd_expect(5'h1f, 16'h0222, "R8 page untouched by gap writes");
    commit_expect(16'h1111, {10'h222, 4'h4, 2'b00}, 32'h11114444, "R8 pending write untouched");

    // R1 foreign PHY addresses
    wr(5'h06, 16'h6666);
    rd_expect(5'h03, pat({10'h222, 4'h3, 2'b00})[15:0], "R5 read before foreign sweep");
    for (int f = 0; f < 31; f++) begin
      drive(1'b1, 5'(f), 5'h1f, 16'h03ff);
      chk(txn_claim == 1'b0, "R1 foreign not claimed", 32'(txn_claim), 32'd0);
      idle();
      drive(1'b1, 5'(f), 5'h06, 16'hdead);
      idle();
      drive(1'b0, 5'(f), 5'h07, 16'h0);
      chk(bus_rd == 1'b0 && bus_wr == 1'b0, "R1 foreign no strobe", {bus_wr, bus_rd}, 32'd0);
      idle();
      chk(rsp_valid == 1'b0, "R1 foreign no response", 32'(rsp_valid), 32'd0);
    end
    rd_expect(5'h1f, 16'h0222, "R1 page unchanged by foreign");
    rd_expect(5'h10, pat({10'h222, 4'h3, 2'b00})[31:16], "R1 upper half unchanged by foreign");
    commit_expect(16'h9999, {10'h222, 4'h6, 2'b00}, 32'h99996666, "R1 pending write unchanged by foreign");

    // R9 idle cycles give no response
    idle();
    chk(rsp_valid == 1'b0, "R9 idle no response", 32'(rsp_valid), 32'd0);
    // R10 strobes exclusive on idle
    chk(!(bus_wr && bus_rd), "R10 strobes exclusive", {bus_wr, bus_rd}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule